// File: doc/BRIEF.md
# SPI Word Shift Engine

This block is the bit-level core of an SPI master. A client offers one word at a time over a valid/ready handshake. Each request carries the word to send, a flag that says whether that data is meaningful, and the word length. The engine asserts the chip select and toggles SCK at a programmable rate. It drives MOSI and samples MISO on the edges picked by the clock phase, so it receives exactly as many bits as it sends. When the word is finished it releases the chip select and returns the received bits right-justified.

A six-bit mode input sets the clock phase (bit 0), clock polarity (bit 1), chip-select polarity (bit 2), bit order (bit 3), three-wire shared-line operation (bit 4) and internal loopback (bit 5). Chip-select polarity acts on the pin immediately. The other mode bits, the divider and the word length are captured when a request is accepted, so they take effect only from the next selection.

The control state machine has three states. ST_IDLE waits for a request, with ready high and the chip select inactive. ST_RUN produces the 2N SCK edges of an N-bit word. ST_TAIL holds the select for one more half period. The transitions are: ST_IDLE to ST_RUN on an accepted request; ST_RUN to ST_TAIL on the half-period tick that produces edge 2N; and ST_TAIL to ST_IDLE on the next tick, which is the cycle in which done pulses.

Top module: `spi_word_engine`

## Requirements
- R1: A request is accepted on a clock edge where req_valid and req_ready are both high. req_ready is low from the next cycle until the word ends. done is high for exactly one cycle, and that cycle is the (2N+1)·(clk_div+1)-th cycle after the accepting edge. req_ready is high again in the following cycle.
- R2: SCK idles at the clock polarity (mode bit 1) captured at acceptance. Each SCK half period lasts clk_div+1 system clocks. A word of N bits produces exactly 2N SCK edges, N of which are leading edges (edges that leave the idle level).
- R3: With clock phase (mode bit 0) clear, data is sampled on leading edges and changed on trailing edges. With it set, data is sampled on trailing edges and changed on leading edges. A receiver that samples MOSI on the sampling edges sees the transmitted word.
- R4: With mode bit 3 clear, each word goes out and comes in most-significant bit first. With it set, each word goes out and comes in least-significant bit first.
- R5: When tx_present is low at acceptance, every bit driven on MOSI during the word is 0, and MISO is still captured.
- R6: rx_word holds the N received bits right-justified, with every bit above N at zero. It is valid in the done cycle and holds until the next acceptance.
- R7: The word length is word_bits clamped to the range 4 to 32. A value below 4 runs a 4-bit word, and a value above 32 runs a 32-bit word.
- R8: The cs pin is active high when mode bit 2 is set and active low when it is clear. It is active exactly while req_ready is low. A change of mode bit 2 reaches the pin in the same cycle, even while idle.
- R9: Changes to mode bits 0, 1, 3, 4, 5, clk_div, word_bits, tx_word or tx_present made while a word is in flight do not affect that word.
- R10: mosi_oe is low only while a word is in flight with three-wire mode (mode bit 4) set and tx_present low at acceptance. Otherwise it is high.
- R11: With loopback (mode bit 5) set, the received word equals the transmitted bits (zero when tx_present was low), and the MISO pin is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Word request offered |
| req_ready | output | 1 | Engine idle and able to accept a request |
| tx_word | input | DATA_W | Word to transmit, right-justified |
| tx_present | input | 1 | Transmit data is meaningful; when low, zeros are sent |
| word_bits | input | BITS_W | Requested word length in bits |
| mode | input | 6 | Phase, polarity, select polarity, bit order, three-wire, loopback |
| clk_div | input | DIV_W | SCK half period minus one, in system clocks |
| done | output | 1 | One-cycle pulse at the end of a word |
| rx_word | output | DATA_W | Received word, right-justified |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out (shared line in three-wire mode) |
| mosi_oe | output | 1 | Output enable for the data line |
| miso | input | 1 | Serial data in |
| cs | output | 1 | Chip select, polarity from mode bit 2 |

## Verification
A wrong edge counter shows up within the first word. It changes the number of SCK edges and the busy length, and done moves by at least one half period. A wrong bit index or a phase decode that picks the wrong edge corrupts MOSI at the first sampling edge. That error appears in the word an external receiver captures and, through loopback, in rx_word at done. A mode register that follows the live input instead of the value captured at acceptance only shows when the mode changes mid-word or between words. The bench therefore changes the mode inside a word and checks the idle SCK level after the word.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_TAIL = 2'd2
    } eng_state_e;

    // field order follows the mode input bit positions (bit 5 down to bit 0)
    typedef struct packed {
        logic loopback;
        logic three_wire;
        logic lsb_first;
        logic cs_high;
        logic cpol;
        logic cpha;
    } eng_mode_t;

endpackage

// File: rtl/spi_eng_fsm.sv
module spi_eng_fsm
    import spi_eng_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       tick,
    input  logic       last_edge,
    output eng_state_e state,
    output logic       accept,
    output logic       done
);

    eng_state_e state_q;
    eng_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid)         state_d = ST_RUN;
            ST_RUN:  if (tick && last_edge) state_d = ST_TAIL;
            ST_TAIL: if (tick)              state_d = ST_IDLE;
            default:                        state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state  = state_q;
        accept = (state_q == ST_IDLE) && req_valid;
        done   = (state_q == ST_TAIL) && tick;
    end

endmodule

// File: rtl/spi_eng_sckgen.sv
module spi_eng_sckgen #(
    parameter int DIV_W  = 16,
    parameter int BITS_W = 6,
    parameter int CNT_W  = BITS_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              active,
    input  logic              shifting,
    input  logic              cpol_in,
    input  logic [DIV_W-1:0]  div_q,
    input  logic [BITS_W-1:0] nbits_q,
    output logic              tick,
    output logic              toggle,
    output logic [CNT_W-1:0]  edge_num,
    output logic              last_edge,
    output logic              sck
);

    logic [DIV_W-1:0] timer_q;
    logic [CNT_W-1:0] edge_cnt_q;
    logic             sck_q;

    assign tick      = active && (timer_q == div_q);
    assign toggle    = tick && shifting;
    assign edge_num  = edge_cnt_q + CNT_W'(1);
    assign last_edge = (edge_num == {nbits_q, 1'b0});
    assign sck       = sck_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            timer_q    <= '0;
            edge_cnt_q <= '0;
            sck_q      <= 1'b0;
        end else if (start) begin
            timer_q    <= '0;
            edge_cnt_q <= '0;
            sck_q      <= cpol_in;
        end else if (active) begin
            timer_q <= tick ? '0 : timer_q + DIV_W'(1);
            if (toggle) begin
                edge_cnt_q <= edge_num;
                sck_q      <= ~sck_q;
            end
        end
    end

endmodule

// File: rtl/spi_eng_shift.sv
module spi_eng_shift #(
    parameter int DATA_W = 32,
    parameter int BITS_W = 6,
    parameter int CNT_W  = BITS_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] tx_in,
    input  logic              txp_in,
    input  logic [BITS_W-1:0] nbits_q,
    input  logic              lsb_q,
    input  logic              cpha_q,
    input  logic              loop_q,
    input  logic              miso,
    input  logic              toggle,
    input  logic [CNT_W-1:0]  edge_num,
    output logic              mosi,
    output logic [DATA_W-1:0] rx_word
);

    localparam int IDX_W = $clog2(DATA_W);

    logic [DATA_W-1:0] tx_q;
    logic [DATA_W-1:0] rx_q;
    logic [BITS_W-1:0] out_idx_q;
    logic [BITS_W-1:0] in_cnt_q;
    logic [IDX_W-1:0]  tx_pos;
    logic [IDX_W-1:0]  rx_pos;
    logic              advance;
    logic              sample;
    logic              in_bit;

    assign tx_pos  = lsb_q ? IDX_W'(out_idx_q)
                           : IDX_W'(nbits_q - BITS_W'(1) - out_idx_q);
    assign rx_pos  = IDX_W'(in_cnt_q);
    assign mosi    = tx_q[tx_pos];
    assign advance = toggle && (edge_num >= CNT_W'(2))
                     && (edge_num < {nbits_q, 1'b0})
                     && (edge_num[0] == cpha_q);
    assign sample  = toggle && (edge_num[0] != cpha_q);
    assign in_bit  = loop_q ? mosi : miso;
    assign rx_word = rx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q      <= '0;
            out_idx_q <= '0;
        end else if (start) begin
            tx_q      <= txp_in ? tx_in : '0;
            out_idx_q <= '0;
        end else if (advance) begin
            out_idx_q <= out_idx_q + BITS_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q     <= '0;
            in_cnt_q <= '0;
        end else if (start) begin
            rx_q     <= '0;
            in_cnt_q <= '0;
        end else if (sample) begin
            in_cnt_q <= in_cnt_q + BITS_W'(1);
            if (lsb_q) rx_q[rx_pos] <= in_bit;
            else       rx_q         <= {rx_q[DATA_W-2:0], in_bit};
        end
    end

endmodule

// File: rtl/spi_word_engine.sv
module spi_word_engine
    import spi_eng_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int DIV_W    = 16,
    parameter int MIN_BITS = 4,
    localparam int BITS_W  = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [DATA_W-1:0] tx_word,
    input  logic              tx_present,
    input  logic [BITS_W-1:0] word_bits,
    input  logic [5:0]        mode,
    input  logic [DIV_W-1:0]  clk_div,
    output logic              done,
    output logic [DATA_W-1:0] rx_word,
    output logic              sck,
    output logic              mosi,
    output logic              mosi_oe,
    input  logic              miso,
    output logic              cs
);

    localparam int CNT_W = BITS_W + 1;

    eng_mode_t         mode_in;
    eng_state_e        state;
    logic              accept;
    logic              busy;
    logic              tick;
    logic              toggle;
    logic              last_edge;
    logic [CNT_W-1:0]  edge_num;
    logic [BITS_W-1:0] nbits_in;

    logic [BITS_W-1:0] nbits_q;
    logic [DIV_W-1:0]  div_q;
    logic              cpha_q;
    logic              lsb_q;
    logic              loop_q;
    logic              tw_q;
    logic              txp_q;

    assign mode_in  = eng_mode_t'(mode);
    assign nbits_in = (word_bits < BITS_W'(MIN_BITS)) ? BITS_W'(MIN_BITS) :
                      (word_bits > BITS_W'(DATA_W))   ? BITS_W'(DATA_W)   :
                      word_bits;

    // settings captured at selection time
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nbits_q <= BITS_W'(MIN_BITS);
            div_q   <= '0;
            cpha_q  <= 1'b0;
            lsb_q   <= 1'b0;
            loop_q  <= 1'b0;
            tw_q    <= 1'b0;
            txp_q   <= 1'b0;
        end else if (accept) begin
            nbits_q <= nbits_in;
            div_q   <= clk_div;
            cpha_q  <= mode_in.cpha;
            lsb_q   <= mode_in.lsb_first;
            loop_q  <= mode_in.loopback;
            tw_q    <= mode_in.three_wire;
            txp_q   <= tx_present;
        end
    end

    spi_eng_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .tick      (tick),
        .last_edge (last_edge),
        .state     (state),
        .accept    (accept),
        .done      (done)
    );

    assign busy = (state != ST_IDLE);

    spi_eng_sckgen #(
        .DIV_W  (DIV_W),
        .BITS_W (BITS_W),
        .CNT_W  (CNT_W)
    ) u_sckgen (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (accept),
        .active    (busy),
        .shifting  (state == ST_RUN),
        .cpol_in   (mode_in.cpol),
        .div_q     (div_q),
        .nbits_q   (nbits_q),
        .tick      (tick),
        .toggle    (toggle),
        .edge_num  (edge_num),
        .last_edge (last_edge),
        .sck       (sck)
    );

    spi_eng_shift #(
        .DATA_W (DATA_W),
        .BITS_W (BITS_W),
        .CNT_W  (CNT_W)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (accept),
        .tx_in    (tx_word),
        .txp_in   (tx_present),
        .nbits_q  (nbits_q),
        .lsb_q    (lsb_q),
        .cpha_q   (cpha_q),
        .loop_q   (loop_q),
        .miso     (miso),
        .toggle   (toggle),
        .edge_num (edge_num),
        .mosi     (mosi),
        .rx_word  (rx_word)
    );

    assign req_ready = !busy;
    assign cs        = mode_in.cs_high ? busy : !busy;
    assign mosi_oe   = !(busy && tw_q && !txp_q);

endmodule

// File: rtl/spi_word_engine_chk.sv
module spi_word_engine_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic done,
    input logic sck,
    input logic cs,
    input logic cs_pol,
    input logic mosi_oe
);

    a_r1_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r1_ready_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> req_ready);

    a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    a_r2_sck_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && !req_valid) |=> $stable(sck));

    a_r8_cs_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (cs == !cs_pol));

    a_r8_cs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |-> (cs == cs_pol));

    a_r10_oe_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !mosi_oe |-> !req_ready);

endmodule

bind spi_word_engine spi_word_engine_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .done      (done),
    .sck       (sck),
    .cs        (cs),
    .cs_pol    (mode[2]),
    .mosi_oe   (mosi_oe)
);

// File: tb/spi_word_engine_tb_top.sv
module spi_word_engine_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    typedef struct {
        logic [5:0]  mode;
        int          n;
        int          d;
        logic [31:0] tx;
        bit          txp;
        logic [31:0] sw;
    } item_t;

    logic        clk;
    logic        rst_n;
    logic        req_valid;
    logic        req_ready;
    logic [31:0] tx_word;
    logic        tx_present;
    logic [5:0]  word_bits;
    logic [5:0]  mode_r;
    logic [15:0] clk_div;
    logic        done;
    logic [31:0] rx_word;
    logic        sck;
    logic        mosi;
    logic        mosi_oe;
    logic        miso;
    logic        cs;

    int total = 0;
    int bad   = 0;
    item_t sb[$];

    spi_word_engine dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .tx_word    (tx_word),
        .tx_present (tx_present),
        .word_bits  (word_bits),
        .mode       (mode_r),
        .clk_div    (clk_div),
        .done       (done),
        .rx_word    (rx_word),
        .sck        (sck),
        .mosi       (mosi),
        .mosi_oe    (mosi_oe),
        .miso       (miso),
        .cs         (cs)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int clampf(input int w);
        return (w < 4) ? 4 : ((w > 32) ? 32 : w);
    endfunction

    function automatic logic [31:0] maskf(input int n);
        return (n >= 32) ? 32'hFFFF_FFFF : 32'((64'd1 << n) - 64'd1);
    endfunction

    // monitor: follows the serial lines, plays the remote device and compares at done
    item_t       cur;
    int          cyc, sc, nlead, nedge;
    logic [31:0] cap;
    logic        psck;
    logic        prdy = 1'b1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (prdy && !req_ready) begin
                cur   = sb[0];
                cyc   = 1;
                sc    = 0;
                nlead = 0;
                nedge = 0;
                cap   = '0;
                psck  = sck;
            end else if (!req_ready) begin
                cyc++;
                if (sck != psck) begin
                    bit lead;
                    nedge++;
                    lead = (sck != cur.mode[1]);
                    if (lead) nlead++;
                    if (lead == !cur.mode[0]) begin
                        if (sc < cur.n) begin
                            if (cur.mode[3]) cap[sc] = mosi;
                            else             cap[cur.n - 1 - sc] = mosi;
                        end
                        sc++;
                    end
                    psck = sck;
                end
            end
            if (!req_ready && sc < cur.n)
                miso = cur.mode[3] ? cur.sw[sc] : cur.sw[cur.n - 1 - sc];
            else
                miso = 1'b0;
            if (done) begin
                logic [31:0] m, etx, erx;
                m   = maskf(cur.n);
                etx = cur.txp ? (cur.tx & m) : 32'h0;
                erx = cur.mode[5] ? etx : (cur.sw & m);
                chk(cyc == (2 * cur.n + 1) * (cur.d + 1), "R1 busy length", 32'(cyc),
                    32'((2 * cur.n + 1) * (cur.d + 1)));
                chk(nlead == cur.n && nedge == 2 * cur.n, "R2 R7 sck edge count",
                    32'(nedge), 32'(2 * cur.n));
                chk(cap == etx, "R3 R4 R5 mosi word seen by receiver", cap, etx);
                chk(rx_word == erx, cur.mode[5] ? "R11 loopback rx_word" : "R6 rx_word",
                    rx_word, erx);
                chk(mosi_oe == !(cur.mode[4] && !cur.txp), "R10 mosi_oe",
                    32'(mosi_oe), 32'(!(cur.mode[4] && !cur.txp)));
                void'(sb.pop_front());
            end
            prdy = req_ready;
        end
    end

    task automatic run_word(input logic [5:0] m, input int d, input int wb,
                            input logic [31:0] tx, input bit txp,
                            input logic [31:0] sw, input bit chg);
        item_t it;
        it.mode = m;
        it.n    = clampf(wb);
        it.d    = d;
        it.tx   = tx;
        it.txp  = txp;
        it.sw   = sw;
        @(negedge clk);
        mode_r     = m;
        clk_div    = 16'(d);
        word_bits  = 6'(wb);
        tx_word    = tx;
        tx_present = txp;
        sb.push_back(it);
        req_valid  = 1'b1;
        @(negedge clk);
        req_valid  = 1'b0;
        if (chg) begin
            // R9: disturb every captured setting except chip-select polarity
            repeat (3) @(negedge clk);
            mode_r     = m ^ 6'b111011;
            clk_div    = 16'(d + 3);
            word_bits  = 6'd7;
            tx_word    = ~tx;
            tx_present = !txp;
        end
        while (sb.size() != 0) @(negedge clk);
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready after word", 32'(req_ready), 32'd1);
    endtask

    initial begin
        rst_n      = 1'b0;
        req_valid  = 1'b0;
        tx_word    = '0;
        tx_present = 1'b0;
        word_bits  = 6'd8;
        mode_r     = 6'b000000;
        clk_div    = '0;
        miso       = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 reset ready", 32'(req_ready), 32'd1);
        chk(done == 1'b0, "R1 reset done", 32'(done), 32'd0);
        chk(sck == 1'b0, "R2 reset sck", 32'(sck), 32'd0);
        chk(cs == 1'b1, "R8 reset cs inactive low-active", 32'(cs), 32'd1);

        // R8: chip-select polarity acts at once while idle
        mode_r = 6'b000100;
        #1;
        chk(cs == 1'b0, "R8 cs follows polarity at once", 32'(cs), 32'd0);
        mode_r = 6'b000000;
        #1;
        chk(cs == 1'b1, "R8 cs restored", 32'(cs), 32'd1);

        // R3 R4: four clock modes, MSB and LSB first
        run_word(6'b000000, 1, 8,  32'h0000_00A5, 1'b1, 32'h0000_003C, 1'b0);
        run_word(6'b000001, 0, 12, 32'h0000_0ABC, 1'b1, 32'h0000_05A5, 1'b0);
        run_word(6'b000010, 2, 16, 32'h0000_8131, 1'b1, 32'h0000_7E0F, 1'b0);
        run_word(6'b000011, 1, 8,  32'h0000_00C6, 1'b1, 32'h0000_0093, 1'b0);
        run_word(6'b001000, 0, 8,  32'h0000_0081, 1'b1, 32'h0000_0061, 1'b0);
        run_word(6'b001011, 2, 13, 32'h0000_1A2B, 1'b1, 32'h0000_0F0E, 1'b0);
        chk(sck == 1'b1, "R2 sck idles at captured polarity", 32'(sck), 32'd1);

        // R5: no transmit data, receive still works
        run_word(6'b000000, 0, 10, 32'hFFFF_FFFF, 1'b0, 32'h0000_02D7, 1'b0);
        // R6: upper bits of tx ignored, rx right-justified
        run_word(6'b000001, 1, 6,  32'hFFFF_FFEA, 1'b1, 32'hFFFF_FF35, 1'b0);
        // R7: clamping of the word length
        run_word(6'b000000, 0, 2,  32'h0000_000B, 1'b1, 32'h0000_0006, 1'b0);
        run_word(6'b001001, 0, 40, 32'hDEAD_BEEF, 1'b1, 32'h1234_5678, 1'b0);
        run_word(6'b000010, 3, 32, 32'h8000_0001, 1'b1, 32'hC3C3_5A5A, 1'b0);

        // R8: active-high select during a word
        run_word(6'b000100, 1, 8,  32'h0000_0055, 1'b1, 32'h0000_00AA, 1'b0);

        // R10: three-wire receive-only and transmit words
        run_word(6'b010000, 1, 8,  32'h0000_0000, 1'b0, 32'h0000_00E1, 1'b0);
        run_word(6'b010001, 0, 8,  32'h0000_004D, 1'b1, 32'h0000_0012, 1'b0);

        // R11: loopback ignores miso
        run_word(6'b100000, 0, 8,  32'h0000_0039, 1'b1, 32'h0000_00C6, 1'b0);
        run_word(6'b101011, 1, 20, 32'h000A_BCDE, 1'b1, 32'h0005_4321, 1'b0);
        run_word(6'b100001, 0, 9,  32'h0000_01FF, 1'b0, 32'h0000_01FF, 1'b0);

        // R9: settings changed mid-word do not affect the word
        run_word(6'b000000, 2, 12, 32'h0000_0963, 1'b1, 32'h0000_0A5C, 1'b1);
        mode_r = 6'b000010;
        repeat (3) @(negedge clk);
        chk(sck == 1'b0, "R9 sck idle keeps captured polarity", 32'(sck), 32'd0);
        run_word(6'b000010, 0, 8,  32'h0000_0017, 1'b1, 32'h0000_00F0, 1'b0);
        chk(sck == 1'b1, "R9 new polarity after next selection", 32'(sck), 32'd1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=done", WATCHDOG);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule